// File: doc/BRIEF.md
# SMBus Alert Response Slave Responder

This block is the part of an I2C slave that answers an SMBus alert poll. A device that needs attention raises an internal alert flag. The host then polls the shared Alert Response Address. It sends that address with the read bit set, and each alerting device replies with its own slave address. This responder watches the bus and picks out START and STOP conditions. It shifts in the first byte after each START.

When that byte is the Alert Response Address with the read bit set, the block acknowledges it, but only if alerting is enabled and the alert flag is pending. It then drives its own configured 7-bit address as the single data byte. The flag is cleared once the host has clocked its acknowledge bit after that byte. In every other case the block leaves SDA released, so the poll goes unanswered by this device.

The bus lines come in already synchronised to the system clock. The block only ever pulls SDA low; it never drives it high. Clock stretching and ordinary register access belong to other parts of the slave.

Top module: `smbus_alert_responder`

## Requirements
- R1: The only byte answered is the 7-bit address 0001100 followed by read bit 1 (wire value 0x19, MSB first). Writes to that address (0x18) and any other address byte get no acknowledge.
- R2: The address byte is acknowledged (SDA pulled low during the ninth clock) only when the enable input is 1 and the alert flag is 1.
- R3: When the enable input is 0 or the alert flag is 0, the poll is not acknowledged, SDA stays released, and the flag keeps its value.
- R4: After acknowledging, the block sends one data byte, MSB first, carrying its own address in bits 7:1 and 0 in bit 0.
- R5: The alert flag drops once the host's acknowledge bit following the data byte has been sampled on the SCL rising edge. The host normally ends the read with a NACK and then a STOP.
- R6: A one-cycle alertSet pulse sets the flag. A set in the same cycle as a clear wins, so the flag stays 1.
- R7: A STOP or START that arrives before the host's acknowledge bit after the data byte leaves the flag set.
- R8: A START or STOP at any point releases SDA. A START begins a fresh address phase, so a repeated START followed by a valid poll is answered again.
- R9: After reset the alert flag is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level |
| alertEnable | input | 1 | 1 allows the block to answer alert polls |
| alertSet | input | 1 | One-cycle pulse that raises the alert flag |
| ownAddr | input | 7 | This device's slave address, returned in the poll |
| sdaPullDown | output | 1 | 1 pulls SDA low |
| alertFlag | output | 1 | Pending-alert flag |

## Verification
The assertions check the cycle-level rules on every clock:
- a set pulse always leaves the flag at 1;
- the flag never drops outside the host-acknowledge phase;
- entry into the acknowledge phase needs both the enable bit and the flag;
- SDA is released right after a STOP.

The bench's directed scenarios cover the rest, which needs a whole bus transfer. That means address decoding of the read bit, the bit order and content of the returned byte, and the flag staying set when a transfer is aborted by STOP or repeated START.

// File: rtl/smbus_alert_pkg.sv
package smbus_alert_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_MACK
  } respState_t;

  typedef struct packed {
    logic clrCnt;
    logic shiftRx;
    logic loadTx;
    logic shiftTx;
    logic clrFlag;
  } dpStrobe_t;

endpackage

// File: rtl/smbus_alert_dp.sv
module smbus_alert_dp
  import smbus_alert_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] POLL_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              alertSet,
  input  dpStrobe_t         strobe,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              cntFull,
  output logic              cntLast,
  output logic              pollRead,
  output logic              txBit,
  output logic              alertFlag
);
  localparam int BYTE_BITS = ADDR_W + 1;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  logic sclQ, sclP, sdaQ, sdaP;
  logic [BYTE_BITS-1:0] rxByte;
  logic [BYTE_BITS-1:0] txByte;
  logic [CNT_W-1:0]     bitCnt;

  // line sampling for edge and condition detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ <= 1'b1; sclP <= 1'b1;
      sdaQ <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn; sclP <= sclQ;
      sdaQ <= sdaIn; sdaP <= sdaQ;
    end
  end

  assign sclRise  = sclQ & ~sclP;
  assign sclFall  = ~sclQ & sclP;
  assign startDet = sclQ & sclP & sdaP & ~sdaQ;
  assign stopDet  = sclQ & sclP & ~sdaP & sdaQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
    end else if (strobe.clrCnt) begin
      bitCnt <= '0;
    end else if (strobe.shiftRx || strobe.shiftTx) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign cntFull = (bitCnt == CNT_W'(BYTE_BITS));
  assign cntLast = (bitCnt == CNT_W'(BYTE_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte <= '0;
    end else if (strobe.shiftRx) begin
      rxByte <= {rxByte[BYTE_BITS-2:0], sdaQ};
    end
  end

  assign pollRead = (rxByte == {POLL_ADDR, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txByte <= '0;
    end else if (strobe.loadTx) begin
      txByte <= {ownAddr, 1'b0};
    end else if (strobe.shiftTx) begin
      txByte <= {txByte[BYTE_BITS-2:0], 1'b0};
    end
  end

  assign txBit = txByte[BYTE_BITS-1];

  // set takes priority over the read-side clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alertFlag <= 1'b0;
    end else if (alertSet) begin
      alertFlag <= 1'b1;
    end else if (strobe.clrFlag) begin
      alertFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/smbus_alert_ctl.sv
module smbus_alert_ctl
  import smbus_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       cntFull,
  input  logic       cntLast,
  input  logic       pollRead,
  input  logic       txBit,
  input  logic       alertFlag,
  input  logic       alertEnable,
  output dpStrobe_t  strobe,
  output logic       sdaPullDown,
  output respState_t state
);
  respState_t nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (stopDet) begin
      nextState = ST_IDLE;
    end else if (startDet) begin
      nextState     = ST_ADDR;
      strobe.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise && !cntFull) strobe.shiftRx = 1'b1;
          if (sclFall && cntFull) begin
            nextState = (pollRead && alertEnable && alertFlag) ? ST_ACK : ST_IDLE;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            nextState     = ST_DATA;
            strobe.loadTx = 1'b1;
            strobe.clrCnt = 1'b1;
          end
        end
        ST_DATA: begin
          if (sclFall) begin
            if (cntLast) nextState = ST_MACK;
            else         strobe.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            strobe.clrFlag = 1'b1;
            nextState      = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign sdaPullDown = (state == ST_ACK) || ((state == ST_DATA) && !txBit);

endmodule

// File: rtl/smbus_alert_responder.sv
module smbus_alert_responder
  import smbus_alert_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] POLL_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              alertEnable,
  input  logic              alertSet,
  input  logic [ADDR_W-1:0] ownAddr,
  output logic              sdaPullDown,
  output logic              alertFlag
);
  dpStrobe_t  strobe;
  respState_t ctlState;
  logic sclRise, sclFall, startDet, stopDet;
  logic cntFull, cntLast, pollRead, txBit;

  smbus_alert_dp #(.ADDR_W(ADDR_W), .POLL_ADDR(POLL_ADDR)) dp_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .alertSet(alertSet), .strobe(strobe),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .cntFull(cntFull), .cntLast(cntLast),
    .pollRead(pollRead), .txBit(txBit), .alertFlag(alertFlag)
  );

  smbus_alert_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .cntFull(cntFull),
    .cntLast(cntLast), .pollRead(pollRead), .txBit(txBit),
    .alertFlag(alertFlag), .alertEnable(alertEnable), .strobe(strobe),
    .sdaPullDown(sdaPullDown), .state(ctlState)
  );

endmodule

// File: rtl/smbus_alert_chk.sv
module smbus_alert_chk
  import smbus_alert_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       alertSet,
  input logic       alertEnable,
  input logic       alertFlag,
  input logic       sdaPullDown,
  input logic       stopDet,
  input respState_t state
);
  // R6: a set pulse always leaves the flag raised
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    alertSet |=> alertFlag);

  // R5, R7: the flag only drops out of the host-acknowledge phase
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alertFlag && !alertSet && state != ST_MACK) |=> alertFlag);

  // R2: entering the acknowledge phase needs enable and flag
  a_r2_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && $past(state) != ST_ACK) |-> $past(alertFlag && alertEnable));

  // R8: STOP releases the line
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stopDet |=> !sdaPullDown);

  // R9: output never unknown out of reset
  a_r9_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({sdaPullDown, alertFlag}));
endmodule

bind smbus_alert_responder smbus_alert_chk chk_i (
  .clk(clk), .rst_n(rst_n), .alertSet(alertSet), .alertEnable(alertEnable),
  .alertFlag(alertFlag), .sdaPullDown(sdaPullDown), .stopDet(stopDet),
  .state(ctlState)
);

// File: tb/smbus_alert_responder_tb_top.sv
module smbus_alert_responder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic en = 1'b0, setP = 1'b0;
  logic [6:0] own = 7'h5A;
  logic pd, flag;
  logic sdaBus;
  int checks = 0, fails = 0;
  localparam int Q = 10;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~pd;

  smbus_alert_responder dut_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaBus),
    .alertEnable(en), .alertSet(setP), .ownAddr(own),
    .sdaPullDown(pd), .alertFlag(flag)
  );

  task automatic waitQ();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic xferBit(input logic b, output logic got);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ();
    got = sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic dummy;
    for (int i = 7; i >= 0; i--) xferBit(d[i], dummy);
    xferBit(1'b1, ack);
  endtask

  task automatic readBits(input int n, output logic [7:0] d);
    logic b;
    d = '0;
    for (int i = 0; i < n; i++) begin
      xferBit(1'b1, b);
      d = {d[6:0], b};
    end
  endtask

  task automatic pulseSet();
    @(posedge clk); #1 setP = 1'b1;
    @(posedge clk); #1 setP = 1'b0;
  endtask

  task automatic t_reset();
    chk(flag == 1'b0, "R9 flag after reset", flag, 0);
    chk(pd == 1'b0, "R9 sda released after reset", pd, 0);
  endtask

  task automatic t_noFlag();
    logic ack;
    en = 1'b1;
    busStart(); sendByte(8'h19, ack); busStop();
    chk(ack == 1'b1, "R3 poll NACK when flag clear", ack, 1);
    chk(flag == 1'b0, "R3 flag stays clear", flag, 0);
  endtask

  task automatic t_disabled();
    logic ack;
    pulseSet(); en = 1'b0;
    busStart(); sendByte(8'h19, ack); busStop();
    chk(ack == 1'b1, "R2 poll NACK when disabled", ack, 1);
    chk(flag == 1'b1, "R3 flag kept while disabled", flag, 1);
    en = 1'b1;
  endtask

  task automatic t_otherAddr();
    logic ack;
    busStart(); sendByte(8'h18, ack); busStop();
    chk(ack == 1'b1, "R1 write to poll address NACK", ack, 1);
    busStart(); sendByte(8'hB5, ack); busStop();
    chk(ack == 1'b1, "R1 other address NACK", ack, 1);
    chk(flag == 1'b1, "R1 flag untouched", flag, 1);
  endtask

  task automatic t_abortStop();
    logic ack; logic [7:0] d;
    busStart(); sendByte(8'h19, ack);
    chk(ack == 1'b0, "R2 poll ACK before abort", ack, 0);
    readBits(3, d);
    busStop();
    chk(pd == 1'b0, "R8 STOP releases sda", pd, 0);
    chk(flag == 1'b1, "R7 STOP mid-byte keeps flag", flag, 1);
  endtask

  task automatic t_repStart();
    logic ack; logic [7:0] d;
    busStart(); sendByte(8'h19, ack); readBits(2, d);
    busStart();
    chk(flag == 1'b1, "R7 repeated START keeps flag", flag, 1);
    sendByte(8'h19, ack);
    chk(ack == 1'b0, "R8 poll answered after repeated START", ack, 0);
    readBits(8, d);
    chk(d == {own, 1'b0}, "R4 byte after repeated START", d, {own, 1'b0});
    xferBit(1'b1, ack); busStop();
    chk(flag == 1'b0, "R5 flag cleared after host NACK", flag, 0);
  endtask

  task automatic t_fullRead(input logic [6:0] addr);
    logic ack; logic [7:0] d;
    own = addr; pulseSet();
    busStart(); sendByte(8'h19, ack);
    chk(ack == 1'b0, "R2 poll ACK", ack, 0);
    readBits(8, d);
    chk(d == {addr, 1'b0}, "R4 returned address byte", d, {addr, 1'b0});
    chk(flag == 1'b1, "R5 flag held until host ack bit", flag, 1);
    xferBit(1'b1, ack);
    chk(pd == 1'b0, "R5 sda released after byte", pd, 0);
    busStop();
    chk(flag == 1'b0, "R5 flag cleared", flag, 0);
  endtask

  task automatic t_setWins();
    logic ack; logic [7:0] d;
    pulseSet();
    busStart(); sendByte(8'h19, ack); readBits(8, d);
    setP = 1'b1;
    xferBit(1'b1, ack);
    setP = 1'b0;
    busStop();
    chk(flag == 1'b1, "R6 set beats clear", flag, 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    waitQ();
    t_reset();
    t_noFlag();
    t_disabled();
    t_otherAddr();
    t_abortStop();
    t_repStart();
    t_fullRead(7'h5A);
    t_fullRead(7'h23);
    own = 7'h5A;
    t_setWins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule